// File: doc/BRIEF.md
# Boot Header Pointer Rewriter for Serial NOR Flash

This controller lets logic inside an FPGA retarget one of the boot pointers kept in the multi-image header at the base of an external serial NOR flash. No external processor is involved. The caller names a header slot and a stored image number. The block works out the image's byte address and checks it against the flash size. It then rebuilds the first erase region of the flash with only that slot's pointer changed. The next warm or cold boot then loads the newly selected image.

The header holds five 32-byte slots. Slot 0 is the image taken after power-on. Slots 1 to 4 are the four selectable boot images. Each slot opens with the marker `7E AA 99 7E`. Its pointer is a 24-bit byte address held most significant byte first at slot offsets 9, 10 and 11. Stored images sit on a 32 KB grid. Image 0 is the exception: it starts at `0x000100`, directly after the header.

The block keeps only one 256-byte chunk on chip. It first copies the region to a spare scratchpad area of the same flash, one chunk at a time. It then erases the region and streams the scratchpad copy back, replacing the three pointer bytes on the way. All flash traffic uses plain single-bit SPI in mode 0.

Top module: `boot_hdr_rewriter`

## Requirements
- R1: A request with `entry_idx_i` above 4 is refused. One cycle after the request, `done_o` and `err_o` are both high and `busy_o` stays low. CS_n never falls for that request.
- R2: A request whose image address is at or above `FLASH_BYTES` is refused in the same way as R1, with no flash access. For example, image 128 or image 511 is refused with a 4 MB flash.
- R3: After a successful request, region bytes 32·e+9, 32·e+10 and 32·e+11 (e = slot) hold the image address most significant byte first. Image 0 gives `00 01 00`. Image x ≥ 1 gives x·0x8000, so image 1 gives `00 80 00`.
- R4: Every other byte of the rewritten region, including each slot's `7E AA 99 7E` marker, keeps the value it had before the request.
- R5: For an accepted request, `busy_o` rises on the cycle after the request. It falls in the same cycle as a done pulse that lasts exactly one cycle. `err_o` is then low.
- R6: The SPI link runs in mode 0, so SCK is low whenever CS_n is high. Between two commands, CS_n stays high for at least 4·`CLK_DIV` clock cycles, which is two SCK periods.
- R7: Every page program (0x02) and sector erase (0x20) is preceded by write-enable (0x06). While an erase or program is in progress, the only command sent is read-status (0x05). Status bit 0 is the busy flag, and it is polled until it reads 0.
- R8: Reads use opcode 0x03 and a 24-bit address sent most significant byte first. Each page program starts on a 256-byte boundary and carries at most `CHUNK_BYTES` data bytes.
- R9: A request raised while `busy_o` is high is ignored. It leaves the flash contents and the done-pulse count unaffected.
- R10: When a request completes, the scratchpad at `SCRATCH_BASE` holds the region exactly as it was before the request, unpatched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a rewrite; sampled while idle |
| entry_idx_i | input | 3 | Header slot to patch, 0..4 |
| image_num_i | input | 9 | Stored image number to point the slot at |
| busy_o | output | 1 | Rewrite in progress |
| done_o | output | 1 | One-cycle completion pulse, also for refusals |
| err_o | output | 1 | Last request was refused; valid from the done pulse |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The bound checker enforces the following on every cycle:
- SCK stays low while the flash is deselected.
- The deselect gap before each command meets its minimum.
- The done strobe lasts one cycle.
- An accepted job ends with `err_o` clear.
- An out-of-range slot is refused at once.
- The SPI bus is quiet while idle.

Only the bench's behavioural flash, with its busy delay, can show the rest: that the whole region survives the erase/rewrite apart from the three target bytes, that the scratchpad holds the pre-request image, that write-enable and busy polling are obeyed, and that a request arriving mid-job changes nothing.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_ERASE = 8'h20;
  localparam logic [7:0] OPC_STAT  = 8'h05;

  localparam int SLOT_BYTES   = 32;
  localparam int PTR_OFFSET   = 9;
  localparam int CMD_HDR_LEN  = 4;  // opcode + 3 address bytes

  typedef enum logic [2:0] {
    OP_WREN,
    OP_ERASE,
    OP_READ,
    OP_PROG,
    OP_POLL
  } op_e;

  typedef enum logic [1:0] {
    PH_SCR_ERASE,
    PH_COPY,
    PH_REG_ERASE,
    PH_BACK
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_LAUNCH,
    ST_XFER
  } state_e;

endpackage

// File: rtl/spi_byte_io.sv
// Mode-0 byte shifter: MOSI set before rise, MISO sampled on rise.
module spi_byte_io #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  assign mosi_o = sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_o     <= '0;
      done_o   <= 1'b0;
      sck_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          sh_q     <= tx_i;
          bit_q    <= '0;
          cnt_q    <= '0;
          sck_o    <= 1'b0;
        end
      end else if (int'(cnt_q) == HALF_DIV - 1) begin
        cnt_q <= '0;
        if (!sck_o) begin
          sck_o <= 1'b1;
          rx_o  <= {rx_o[6:0], miso_i};
        end else begin
          sck_o <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/chunk_buf.sv
module chunk_buf #(
  parameter int DEPTH = 256
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [7:0]               wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [7:0]               rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ptr_encoder.sv
module ptr_encoder #(
  parameter int FLASH_BYTES = 4194304
) (
  input  logic [2:0]  entry_idx_i,
  input  logic [8:0]  image_num_i,
  output logic [23:0] ptr_o,
  output logic        bad_entry_o,
  output logic        bad_image_o
);

  assign ptr_o       = (image_num_i == 9'd0) ? 24'h000100 : {image_num_i, 15'd0};
  assign bad_entry_o = entry_idx_i > 3'd4;
  assign bad_image_o = {8'h00, ptr_o} >= 32'(FLASH_BYTES);

endmodule

// File: rtl/boot_hdr_rewriter.sv
module boot_hdr_rewriter
  import boot_hdr_pkg::*;
#(
  parameter int          CLK_DIV      = 2,
  parameter int          FLASH_BYTES  = 4194304,
  parameter logic [23:0] SCRATCH_BASE = 24'h3FF000,
  parameter int          REGION_BYTES = 4096,
  parameter int          CHUNK_BYTES  = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] entry_idx_i,
  input  logic [8:0] image_num_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       spi_sck_o,
  output logic       spi_cs_no,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);

  localparam int N_CHUNKS = REGION_BYTES / CHUNK_BYTES;
  localparam int NW       = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1;
  localparam int AW       = $clog2(CHUNK_BYTES);
  localparam int BW       = $clog2(CHUNK_BYTES + CMD_HDR_LEN + 1);
  localparam int GAP_CYC  = 4 * CLK_DIV;
  localparam int GW       = $clog2(GAP_CYC + 1);

  state_e        state_q;
  op_e           op_q;
  phase_e        phase_q;
  logic [NW-1:0] chunk_q;
  logic [BW-1:0] bidx_q;
  logic [GW-1:0] gap_q;
  logic [23:0]   ptr_q;
  logic [2:0]    entry_q;

  logic [23:0] req_ptr;
  logic        bad_entry, bad_image;
  logic        byte_start, byte_done;
  logic [7:0]  tx_byte, rx_byte;
  logic [7:0]  opcode, buf_rd, prog_byte;
  logic [23:0] cmd_addr, chunk_off;
  logic [AW-1:0] data_idx;
  logic        buf_we;
  int          ncmd, patch_pos;
  logic        last_chunk;

  ptr_encoder #(.FLASH_BYTES(FLASH_BYTES)) u_ptr (
    .entry_idx_i (entry_idx_i),
    .image_num_i (image_num_i),
    .ptr_o       (req_ptr),
    .bad_entry_o (bad_entry),
    .bad_image_o (bad_image)
  );

  spi_byte_io #(.HALF_DIV(CLK_DIV)) u_spi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (byte_start),
    .tx_i    (tx_byte),
    .rx_o    (rx_byte),
    .done_o  (byte_done),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .miso_i  (spi_miso_i)
  );

  chunk_buf #(.DEPTH(CHUNK_BYTES)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .waddr_i (data_idx),
    .wdata_i (rx_byte),
    .raddr_i (data_idx),
    .rdata_o (buf_rd)
  );

  assign byte_start = (state_q == ST_LAUNCH);
  assign data_idx   = AW'(bidx_q - BW'(CMD_HDR_LEN));
  assign buf_we     = byte_done && (op_q == OP_READ) && (int'(bidx_q) >= CMD_HDR_LEN);
  assign chunk_off  = 24'(int'(chunk_q) * CHUNK_BYTES);
  assign last_chunk = (int'(chunk_q) == N_CHUNKS - 1);

  always_comb begin
    unique case (op_q)
      OP_WREN:  begin opcode = OPC_WREN;  ncmd = 1; end
      OP_ERASE: begin opcode = OPC_ERASE; ncmd = CMD_HDR_LEN; end
      OP_READ:  begin opcode = OPC_READ;  ncmd = CMD_HDR_LEN + CHUNK_BYTES; end
      OP_PROG:  begin opcode = OPC_PROG;  ncmd = CMD_HDR_LEN + CHUNK_BYTES; end
      default:  begin opcode = OPC_STAT;  ncmd = 2; end
    endcase
  end

  always_comb begin
    unique case (op_q)
      OP_ERASE: cmd_addr = (phase_q == PH_SCR_ERASE) ? SCRATCH_BASE : 24'h0;
      OP_READ:  cmd_addr = (phase_q == PH_COPY) ? chunk_off : SCRATCH_BASE + chunk_off;
      OP_PROG:  cmd_addr = (phase_q == PH_COPY) ? SCRATCH_BASE + chunk_off : chunk_off;
      default:  cmd_addr = 24'h0;
    endcase
  end

  // Pointer substitution only on the write-back of the header chunk
  always_comb begin
    patch_pos = int'(entry_q) * SLOT_BYTES + PTR_OFFSET;
    prog_byte = buf_rd;
    if (phase_q == PH_BACK && chunk_q == '0) begin
      if (int'(data_idx) == patch_pos)          prog_byte = ptr_q[23:16];
      else if (int'(data_idx) == patch_pos + 1) prog_byte = ptr_q[15:8];
      else if (int'(data_idx) == patch_pos + 2) prog_byte = ptr_q[7:0];
    end
  end

  always_comb begin
    unique case (int'(bidx_q))
      0:       tx_byte = opcode;
      1:       tx_byte = cmd_addr[23:16];
      2:       tx_byte = cmd_addr[15:8];
      3:       tx_byte = cmd_addr[7:0];
      default: tx_byte = (op_q == OP_PROG) ? prog_byte : 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_WREN;
      phase_q   <= PH_SCR_ERASE;
      chunk_q   <= '0;
      bidx_q    <= '0;
      gap_q     <= '0;
      ptr_q     <= '0;
      entry_q   <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      spi_cs_no <= 1'b1;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (bad_entry || bad_image) begin
              err_o  <= 1'b1;
              done_o <= 1'b1;
            end else begin
              err_o   <= 1'b0;
              busy_o  <= 1'b1;
              entry_q <= entry_idx_i;
              ptr_q   <= req_ptr;
              phase_q <= PH_SCR_ERASE;
              op_q    <= OP_WREN;
              chunk_q <= '0;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (int'(gap_q) == GAP_CYC - 1) begin
            bidx_q    <= '0;
            spi_cs_no <= 1'b0;
            state_q   <= ST_LAUNCH;
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        ST_LAUNCH: state_q <= ST_XFER;
        ST_XFER: begin
          if (byte_done) begin
            if (int'(bidx_q) == ncmd - 1) begin
              spi_cs_no <= 1'b1;
              gap_q     <= '0;
              state_q   <= ST_GAP;
              unique case (op_q)
                OP_WREN:  op_q <= (phase_q == PH_SCR_ERASE || phase_q == PH_REG_ERASE)
                                  ? OP_ERASE : OP_PROG;
                OP_ERASE: op_q <= OP_POLL;
                OP_READ:  op_q <= OP_WREN;
                OP_PROG:  op_q <= OP_POLL;
                default: begin
                  if (!rx_byte[0]) begin
                    unique case (phase_q)
                      PH_SCR_ERASE: begin
                        phase_q <= PH_COPY;
                        op_q    <= OP_READ;
                        chunk_q <= '0;
                      end
                      PH_COPY: begin
                        if (last_chunk) begin
                          phase_q <= PH_REG_ERASE;
                          op_q    <= OP_WREN;
                        end else begin
                          chunk_q <= chunk_q + NW'(1);
                          op_q    <= OP_READ;
                        end
                      end
                      PH_REG_ERASE: begin
                        phase_q <= PH_BACK;
                        op_q    <= OP_READ;
                        chunk_q <= '0;
                      end
                      default: begin
                        if (last_chunk) begin
                          busy_o  <= 1'b0;
                          done_o  <= 1'b1;
                          state_q <= ST_IDLE;
                        end else begin
                          chunk_q <= chunk_q + NW'(1);
                          op_q    <= OP_READ;
                        end
                      end
                    endcase
                  end
                end
              endcase
            end else begin
              bidx_q  <= bidx_q + BW'(1);
              state_q <= ST_LAUNCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/boot_hdr_rewriter_chk.sv
module boot_hdr_rewriter_chk #(
  parameter int CLK_DIV = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [2:0] entry_idx_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       spi_sck_o,
  input logic       spi_cs_no
);

  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt <= 16'hFFFF;
    else if (!spi_cs_no)  hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R6

  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> hi_cnt >= 16'(4 * CLK_DIV)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_FINISH_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && !err_o)); // R5

  AST_BAD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && entry_idx_i > 3'd4) |=> (done_o && err_o && !busy_o)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> spi_cs_no); // R1

endmodule

bind boot_hdr_rewriter boot_hdr_rewriter_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .entry_idx_i (entry_idx_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .spi_sck_o   (spi_sck_o),
  .spi_cs_no   (spi_cs_no)
);

// File: tb/tb_boot_hdr_rewriter.sv
`timescale 1ns/1ps
module tb_boot_hdr_rewriter;

  localparam int          REG   = 512;
  localparam int          CHUNK = 256;
  localparam logic [23:0] SCR   = 24'h3FF000;
  localparam int          FBYTES = 4194304;
  localparam int          BUSY_CYC = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] entry = '0;
  logic [8:0] image = '0;
  logic busy, done, err, sck, cs_n, mosi, miso;

  always #2.5 clk = ~clk;

  boot_hdr_rewriter #(
    .CLK_DIV(1), .FLASH_BYTES(FBYTES), .SCRATCH_BASE(SCR),
    .REGION_BYTES(REG), .CHUNK_BYTES(CHUNK)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .entry_idx_i(entry),
    .image_num_i(image), .busy_o(busy), .done_o(done), .err_o(err),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // ---------------- behavioural flash ----------------
  logic [7:0] reg_mem [REG];
  logic [7:0] scr_mem [REG];
  logic [7:0] exp_mem [REG];
  int cyc = 0, busy_end = 0;
  int bit_cnt = 0, byte_cnt = 0, pp_cnt = 0;
  logic [7:0] in_sh = '0, out_sh = 8'hFF, next_out = 8'hFF, opc = '0;
  logic [23:0] faddr = '0, pp_base = '0;
  logic wel = 1'b0, load_pend = 1'b0;
  int viol_wel = 0, viol_busy = 0, viol_page = 0, viol_range = 0;
  int cs_falls = 0, done_cnt = 0, min_gap = 1000000, hi_run = 0, sck_bad = 0;

  assign miso = out_sh[7];

  function automatic logic [7:0] rd(input logic [23:0] a);
    if (int'(a) < REG) return reg_mem[int'(a)];
    if (a >= SCR && int'(a - SCR) < REG) return scr_mem[int'(a - SCR)];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (cs_n && sck) sck_bad <= sck_bad + 1;
    if (cs_n) hi_run <= hi_run + 1;
    else begin
      if (hi_run > 0 && hi_run < min_gap && cs_falls > 0) min_gap <= hi_run;
      hi_run <= 0;
    end
  end

  always @(negedge cs_n) begin
    cs_falls = cs_falls + 1;
    bit_cnt = 0; byte_cnt = 0; pp_cnt = 0;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      in_sh = {in_sh[6:0], mosi};
      bit_cnt = bit_cnt + 1;
      if (bit_cnt == 8) begin
        bit_cnt = 0;
        if (byte_cnt == 0) begin
          opc = in_sh;
          if (cyc < busy_end && in_sh != 8'h05) viol_busy = viol_busy + 1;
          if (in_sh == 8'h05) begin next_out = {7'b0, cyc < busy_end}; load_pend = 1'b1; end
        end else if (byte_cnt <= 3) begin
          faddr = {faddr[15:0], in_sh};
          if (byte_cnt == 3) begin
            pp_base = faddr;
            if (opc == 8'h03) begin next_out = rd(faddr); load_pend = 1'b1; end
          end
        end else begin
          if (opc == 8'h03) begin
            faddr = faddr + 24'd1; next_out = rd(faddr); load_pend = 1'b1;
          end else if (opc == 8'h02) begin
            logic [23:0] pa;
            pa = {pp_base[23:8], 8'(pp_base[7:0] + 8'(pp_cnt))};
            if (int'(pa) < REG) reg_mem[int'(pa)] = reg_mem[int'(pa)] & in_sh;
            else if (pa >= SCR && int'(pa - SCR) < REG)
              scr_mem[int'(pa - SCR)] = scr_mem[int'(pa - SCR)] & in_sh;
            else viol_range = viol_range + 1;
            pp_cnt = pp_cnt + 1;
          end else if (opc == 8'h05) begin
            next_out = {7'b0, cyc < busy_end}; load_pend = 1'b1;
          end
        end
        byte_cnt = byte_cnt + 1;
      end
    end
  end

  always @(negedge sck) begin
    if (load_pend) begin out_sh = next_out; load_pend = 1'b0; end
    else out_sh = {out_sh[6:0], 1'b1};
  end

  always @(posedge cs_n) begin
    if (byte_cnt > 0) begin
      if (opc == 8'h06) wel = 1'b1;
      else if (opc == 8'h02 || opc == 8'h20) begin
        if (!wel) viol_wel = viol_wel + 1;
        wel = 1'b0;
        busy_end = cyc + BUSY_CYC;
        if (opc == 8'h02 && (pp_cnt > CHUNK || pp_base[7:0] != 8'h00 || byte_cnt < 4))
          viol_page = viol_page + 1;
        if (opc == 8'h20) begin
          if (pp_base == 24'h0) for (int i = 0; i < REG; i++) reg_mem[i] = 8'hFF;
          else if (pp_base == SCR) for (int i = 0; i < REG; i++) scr_mem[i] = 8'hFF;
          else viol_range = viol_range + 1;
        end
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [23:0] img_addr(input logic [8:0] n);
    return (n == 9'd0) ? 24'h000100 : {n, 15'd0};
  endfunction

  task automatic fill_region();
    logic [23:0] p [5];
    p[0] = 24'h000100; p[1] = 24'h000100; p[2] = 24'h008000;
    p[3] = 24'h010000; p[4] = 24'h018000;
    for (int i = 0; i < REG; i++) begin
      logic [7:0] b;
      int e, o;
      e = i / 32; o = i % 32;
      if (i < 160) begin
        case (o)
          0: b = 8'h7E; 1: b = 8'hAA; 2: b = 8'h99; 3: b = 8'h7E;
          4: b = 8'h92; 7: b = 8'h44; 8: b = 8'h03;
          9: b = p[e][23:16]; 10: b = p[e][15:8]; 11: b = p[e][7:0];
          12: b = 8'h82; 15: b = 8'h01; 16: b = 8'h08;
          default: b = 8'h00;
        endcase
      end else if (i < 256) b = 8'hFF;
      else b = 8'(i * 7) ^ 8'h5A;
      reg_mem[i] = b; exp_mem[i] = b; scr_mem[i] = 8'hFF;
    end
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_region(input string rq, input string what);
    int bad;
    bad = 0;
    for (int i = 0; i < REG; i++) if (reg_mem[i] != exp_mem[i]) bad++;
    chk(bad == 0, rq, what, bad, 0);
  endtask

  task automatic run_good(input logic [2:0] e, input logic [8:0] n, input logic extra_req);
    logic ok;
    int d0, other_bad, scr_bad;
    logic [23:0] pa;
    d0 = done_cnt;
    @(negedge clk); entry = e; image = n; req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1, "R5", "busy after accept", busy, 1);
    if (extra_req) begin
      repeat (200) @(negedge clk);
      entry = 3'd1; image = 9'd9; req = 1'b1;   // R9: must be ignored
      @(negedge clk); req = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R5", "done seen", ok, 1);
    chk(!err && !busy, "R5", "err/busy at done", {err, busy}, 0);
    @(negedge clk);
    chk(!done, "R5", "done single cycle", done, 0);
    // scratch holds pre-request image
    scr_bad = 0;
    for (int i = 0; i < REG; i++) if (scr_mem[i] != exp_mem[i]) scr_bad++;
    chk(scr_bad == 0, "R10", "scratch copy mismatches", scr_bad, 0);
    pa = img_addr(n);
    other_bad = 0;
    for (int i = 0; i < REG; i++) begin
      int pos;
      pos = int'(e) * 32 + 9;
      if (i < pos || i > pos + 2) if (reg_mem[i] != exp_mem[i]) other_bad++;
    end
    chk(other_bad == 0, "R4", "non-pointer bytes changed", other_bad, 0);
    chk({reg_mem[int'(e)*32+9], reg_mem[int'(e)*32+10], reg_mem[int'(e)*32+11]} == pa,
        "R3", "pointer bytes",
        int'({reg_mem[int'(e)*32+9], reg_mem[int'(e)*32+10], reg_mem[int'(e)*32+11]}),
        int'(pa));
    chk({reg_mem[int'(e)*32], reg_mem[int'(e)*32+1], reg_mem[int'(e)*32+2],
         reg_mem[int'(e)*32+3]} == 32'h7EAA997E, "R4", "slot marker",
        int'({reg_mem[int'(e)*32], reg_mem[int'(e)*32+3]}), 16'h7E7E);
    if (extra_req) chk(done_cnt - d0 == 1, "R9", "done pulses during job", done_cnt - d0, 1);
    exp_mem[int'(e)*32+9] = pa[23:16];
    exp_mem[int'(e)*32+10] = pa[15:8];
    exp_mem[int'(e)*32+11] = pa[7:0];
    if (extra_req) check_region("R9", "ignored request altered region");
  endtask

  task automatic run_bad(input logic [2:0] e, input logic [8:0] n, input string rq);
    int f0;
    f0 = cs_falls;
    @(negedge clk); entry = e; image = n; req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(done && err && !busy, rq, "refusal flags done/err/busy", {done, err, busy}, 3'b110);
    repeat (20) @(negedge clk);
    chk(cs_falls == f0, rq, "flash accessed on refusal", cs_falls - f0, 0);
    check_region(rq, "region changed on refusal");
  endtask

  // {entry, image, expect_err}
  localparam logic [12:0] VEC [6] = '{
    {3'd5, 9'd3,   1'b1},   // R1
    {3'd7, 9'd0,   1'b1},   // R1
    {3'd1, 9'd128, 1'b1},   // R2
    {3'd3, 9'd511, 1'b1},   // R2
    {3'd0, 9'd1,   1'b0},   // R3: 00 80 00 in slot 0
    {3'd4, 9'd127, 1'b0}    // R3: last slot, last 4 MB image
  };

  initial begin
    fill_region();
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && cs_n && !sck, "R5", "reset outputs",
        {busy, done, err, cs_n, sck}, 5'b00010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][0]) run_bad(VEC[v][12:10], VEC[v][9:1], (v < 2) ? "R1" : "R2");
      else run_good(VEC[v][12:10], VEC[v][9:1], 1'b0);
    end
    // image 0 to slot 2 with a stray request mid-job
    run_good(3'd2, 9'd0, 1'b1);
    chk(min_gap >= 4, "R6", "min CS_n high gap", min_gap, 4);
    chk(sck_bad == 0, "R6", "SCK high while deselected", sck_bad, 0);
    chk(viol_wel == 0 && viol_busy == 0, "R7", "write-enable/busy violations",
        viol_wel + viol_busy, 0);
    chk(viol_page == 0 && viol_range == 0, "R8", "program/address violations",
        viol_page + viol_range, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired: actual=%0d expected=%0d", 195000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule